// File: doc/BRIEF.md
# Interrupt Detection and Entry Sequencer

This block sits beside the control path of an 8-bit processor core that follows the classic stack-based interrupt model. Once per active CPU cycle it samples a non-maskable interrupt line and a bank of maskable interrupt sources. From these samples it keeps a one-cycle-delayed request that the core consults at each instruction boundary. When the core reports a boundary and a request is present, or when the core has just decoded a software break opcode, the block takes over the memory bus. It then runs the entry sequence: discarded reads at the program counter, three stack pushes, and a two-byte vector fetch.

The vector is picked at the moment the status byte is pushed. A non-maskable request that is pending at that point redirects both hardware and software entries to the non-maskable vector, and consumes the request. When the sequence finishes, the block returns the new program counter and stack pointer to the core, and it pulses a strobe telling the core to set its interrupt-disable flag.

The bus port is a request stream. The block raises `bus_valid` with an address, a direction and write data. A transfer completes on a rising clock edge where `bus_valid` and `bus_ready` are both high, and read data is taken from `bus_rdata` in that same cycle. While `bus_ready` is low the block holds every request field unchanged and does not advance. Detection is gated by `cyc_en` and is independent of bus back-pressure.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset there is no bus request, `busy`, `int_pending` and `entry_done` are low, and the source mask is all ones, so any single source bit raises a request.
- R2: A low-to-high change of `nmi_line` seen across two active cycles (`cyc_en` high) makes `int_pending` high after the second active edge following the rise, and not after the first. A line held high does not request again once consumed, and no detection happens while `cyc_en` is low.
- R3: The maskable request is `(irq_src & mask) != 0` with `i_flag` low, sampled each active cycle. It shows on `int_pending` after two active edges, and is blocked when `i_flag` is high.
- R4: A hardware entry issues, in order: a read at `cur_pc`, a second read at `cur_pc`, a write of PC[15:8] to address {0x01, SP}, a write of PC[7:0] to {0x01, SP-1}, a write of the status to {0x01, SP-2} with bit 5 set and bit 4 cleared, then reads of the vector low byte and high byte.
- R5: The NMI vector is at 0xFFFA/0xFFFB and the maskable/break vector at 0xFFFE/0xFFFF, read low byte first. On completion `entry_done` pulses for one cycle with `new_pc` = {high, low} and `new_sp` = SP-3, and `set_i` pulses exactly once per entry, on the status push.
- R6: An NMI request that becomes pending before the status push of a maskable entry sends it to the NMI vector, and taking it clears the request.
- R7: A software break (`brk_exec` at a boundary) issues one read at `cur_pc`, pushes `cur_pc`+1 high then low, pushes status with bits 4 and 5 set, and uses the NMI vector if an NMI is pending at the status push.
- R8: When a software break completes, the delayed NMI request is cleared, so `int_pending` is low in the `entry_done` cycle even with an NMI pending, and rises one active cycle later. A hardware entry does not clear it.
- R9: A `mask_wr` pulse loads `mask_din` into the mask, and sources whose mask bit is zero raise no request.
- R10: While `bus_valid` is high and `bus_ready` is low, the address, direction and write data stay stable and the sequence does not advance.
- R11: A boundary with no pending request and no break starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | CPU cycle strobe that gates sampling |
| nmi_line | input | 1 | Non-maskable request, active high |
| irq_src | input | IRQ_N | Maskable request sources |
| mask_wr | input | 1 | Load strobe for the source mask |
| mask_din | input | IRQ_N | New source mask value |
| i_flag | input | 1 | Core interrupt-disable flag |
| at_boundary | input | 1 | Core is at an instruction boundary |
| brk_exec | input | 1 | Boundary is a software break |
| cur_pc | input | 16 | PC (address after the opcode for a break) |
| cur_sp | input | 8 | Stack pointer |
| cur_status | input | 8 | Status register |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Request address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, taken at the handshake |
| int_pending | output | 1 | Delayed request seen at a boundary |
| busy | output | 1 | Entry sequence in progress |
| set_i | output | 1 | Set the interrupt-disable flag |
| entry_done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler address |
| new_sp | output | 8 | Stack pointer after the pushes |

## Verification
On every cycle the assertions check the local rules: the edge that latches an NMI, the blocking of maskable requests by the disable flag, the one-cycle delay between the latched and the delayed request, its clearing after a break, stability under back-pressure, stack-page addressing, and that an idle boundary without cause stays idle. Only the bench scenarios can show the full bus order and data of each entry, the choice of vector when an NMI arrives at various points of a sequence, the two-cycle latency seen at the ports, and the one-cycle gap in `int_pending` after a break.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DUMMY_A = 3'd1,
    ST_DUMMY_B = 3'd2,
    ST_PUSH_HI = 3'd3,
    ST_PUSH_LO = 3'd4,
    ST_PUSH_ST = 3'd5,
    ST_VEC_LO  = 3'd6,
    ST_VEC_HI  = 3'd7
  } seq_st_e;

  localparam int unsigned STAT_BRK_BIT = 4;
  localparam int unsigned STAT_RSV_BIT = 5;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IRQ_N-1:0] din,
  output logic [IRQ_N-1:0] mask
);

  for (genvar b = 0; b < IRQ_N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask[b] <= 1'b1;
      else if (wr) mask[b] <= din[b];
    end
  end

endmodule

// File: rtl/int_detect.sv
module int_detect #(
  parameter int unsigned IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             nmi_line,
  input  logic [IRQ_N-1:0] irq_src,
  input  logic [IRQ_N-1:0] irq_mask,
  input  logic             i_flag,
  input  logic             nmi_take,
  input  logic             brk_done,
  output logic             nmi_pend,
  output logic             int_pending
);

  logic             nmi_prev;
  logic             nmi_seen;
  logic             irq_run;
  logic             irq_prev;
  logic [IRQ_N-1:0] live_src;
  logic             nmi_edge;

  for (genvar s = 0; s < IRQ_N; s++) begin : g_src
    assign live_src[s] = irq_src[s] & irq_mask[s];
  end

  assign nmi_edge = cyc_en && !nmi_prev && nmi_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
      nmi_seen <= 1'b0;
      irq_run  <= 1'b0;
      irq_prev <= 1'b0;
    end else begin
      if (cyc_en) begin
        nmi_prev <= nmi_line;
        irq_run  <= (|live_src) && !i_flag;
        irq_prev <= irq_run;
      end
      if (nmi_edge)      nmi_pend <= 1'b1;
      else if (nmi_take) nmi_pend <= 1'b0;
      if (nmi_take || brk_done) nmi_seen <= 1'b0;
      else if (cyc_en)          nmi_seen <= nmi_pend;
    end
  end

  assign int_pending = nmi_seen | irq_prev;

  p_pend_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !nmi_prev && nmi_line) |=> nmi_pend);

  p_seen_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !nmi_take && !brk_done) |=> (nmi_seen == $past(nmi_pend)));

  p_iflag_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && i_flag) |=> !irq_run);

  p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take && !nmi_edge) |=> !nmi_pend);

  p_brk_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !nmi_seen);

endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        at_boundary,
  input  logic        brk_exec,
  input  logic        int_pending,
  input  logic        nmi_pend,
  input  logic [15:0] cur_pc,
  input  logic [7:0]  cur_sp,
  input  logic [7:0]  cur_status,
  input  logic        bus_ready,
  input  logic [7:0]  bus_rdata,
  output logic        bus_valid,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        busy,
  output logic        set_i,
  output logic        nmi_take,
  output logic        brk_done,
  output logic        entry_done,
  output logic [15:0] new_pc,
  output logic [7:0]  new_sp
);

  localparam logic [7:0] BRK_M = 8'(1 << STAT_BRK_BIT);
  localparam logic [7:0] RSV_M = 8'(1 << STAT_RSV_BIT);

  seq_st_e     st;
  logic        is_brk;
  logic        use_nmi;
  logic [15:0] pc_q;
  logic [7:0]  sp_q;
  logic [7:0]  stat_q;
  logic [7:0]  vec_lo;
  logic        hs;
  logic        start;
  logic [15:0] push_pc;
  logic [15:0] vec_base;
  logic [7:0]  stat_push;

  assign start     = (st == ST_IDLE) && at_boundary && (brk_exec || int_pending);
  assign push_pc   = pc_q + {15'd0, is_brk};
  assign vec_base  = use_nmi ? NMI_VEC : IRQ_VEC;
  assign stat_push = is_brk ? (stat_q | BRK_M | RSV_M) : ((stat_q & ~BRK_M) | RSV_M);
  assign bus_valid = (st != ST_IDLE);
  assign busy      = bus_valid;
  assign hs        = bus_valid && bus_ready;
  assign set_i     = hs && (st == ST_PUSH_ST);
  assign nmi_take  = set_i && nmi_pend;
  assign brk_done  = hs && (st == ST_VEC_HI) && is_brk;

  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = pc_q;
    bus_wdata = 8'h00;
    case (st)
      ST_PUSH_HI: begin
        bus_we = 1'b1; bus_addr = {STACK_PAGE, sp_q}; bus_wdata = push_pc[15:8];
      end
      ST_PUSH_LO: begin
        bus_we = 1'b1; bus_addr = {STACK_PAGE, sp_q}; bus_wdata = push_pc[7:0];
      end
      ST_PUSH_ST: begin
        bus_we = 1'b1; bus_addr = {STACK_PAGE, sp_q}; bus_wdata = stat_push;
      end
      ST_VEC_LO: bus_addr = vec_base;
      ST_VEC_HI: bus_addr = vec_base + 16'd1;
      default:   bus_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      is_brk     <= 1'b0;
      use_nmi    <= 1'b0;
      pc_q       <= 16'h0000;
      sp_q       <= 8'h00;
      stat_q     <= 8'h00;
      vec_lo     <= 8'h00;
      entry_done <= 1'b0;
      new_pc     <= 16'h0000;
      new_sp     <= 8'h00;
    end else begin
      entry_done <= 1'b0;
      if (start) begin
        is_brk  <= brk_exec;
        use_nmi <= 1'b0;
        pc_q    <= cur_pc;
        sp_q    <= cur_sp;
        stat_q  <= cur_status;
        st      <= brk_exec ? ST_DUMMY_B : ST_DUMMY_A;
      end else if (hs) begin
        case (st)
          ST_DUMMY_A: st <= ST_DUMMY_B;
          ST_DUMMY_B: st <= ST_PUSH_HI;
          ST_PUSH_HI: begin sp_q <= sp_q - 8'd1; st <= ST_PUSH_LO; end
          ST_PUSH_LO: begin sp_q <= sp_q - 8'd1; st <= ST_PUSH_ST; end
          ST_PUSH_ST: begin
            sp_q    <= sp_q - 8'd1;
            use_nmi <= nmi_pend;
            st      <= ST_VEC_LO;
          end
          ST_VEC_LO:  begin vec_lo <= bus_rdata; st <= ST_VEC_HI; end
          ST_VEC_HI: begin
            new_pc     <= {bus_rdata, vec_lo};
            new_sp     <= sp_q;
            entry_done <= 1'b1;
            st         <= ST_IDLE;
          end
          default:    st <= ST_IDLE;
        endcase
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

  p_push_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |-> (bus_addr[15:8] == STACK_PAGE));

  p_done_after_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> $past(bus_valid && bus_ready && !bus_we));

  p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !(at_boundary && (brk_exec || int_pending))) |=> !bus_valid);

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int unsigned IRQ_N      = 8,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             nmi_line,
  input  logic [IRQ_N-1:0] irq_src,
  input  logic             mask_wr,
  input  logic [IRQ_N-1:0] mask_din,
  input  logic             i_flag,
  input  logic             at_boundary,
  input  logic             brk_exec,
  input  logic [15:0]      cur_pc,
  input  logic [7:0]       cur_sp,
  input  logic [7:0]       cur_status,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_we,
  output logic [15:0]      bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             int_pending,
  output logic             busy,
  output logic             set_i,
  output logic             entry_done,
  output logic [15:0]      new_pc,
  output logic [7:0]       new_sp
);

  logic [IRQ_N-1:0] mask_q;
  logic             nmi_pend;
  logic             nmi_take;
  logic             brk_done;

  irq_mask_reg #(.IRQ_N(IRQ_N)) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (mask_wr),
    .din  (mask_din),
    .mask (mask_q)
  );

  int_detect #(.IRQ_N(IRQ_N)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_en     (cyc_en),
    .nmi_line   (nmi_line),
    .irq_src    (irq_src),
    .irq_mask   (mask_q),
    .i_flag     (i_flag),
    .nmi_take   (nmi_take),
    .brk_done   (brk_done),
    .nmi_pend   (nmi_pend),
    .int_pending(int_pending)
  );

  entry_seq #(
    .NMI_VEC   (NMI_VEC),
    .IRQ_VEC   (IRQ_VEC),
    .STACK_PAGE(STACK_PAGE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .at_boundary(at_boundary),
    .brk_exec   (brk_exec),
    .int_pending(int_pending),
    .nmi_pend   (nmi_pend),
    .cur_pc     (cur_pc),
    .cur_sp     (cur_sp),
    .cur_status (cur_status),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .set_i      (set_i),
    .nmi_take   (nmi_take),
    .brk_done   (brk_done),
    .entry_done (entry_done),
    .new_pc     (new_pc),
    .new_sp     (new_sp)
  );

  p_done_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);

endmodule

// File: tb/tb_irq_entry_unit.sv
`timescale 1ns/1ps
module tb_irq_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_en, nmi_line, mask_wr, i_flag, at_boundary, brk_exec, bus_ready;
  logic [7:0]  irq_src, mask_din, cur_sp, cur_status, bus_rdata;
  logic [15:0] cur_pc;
  logic        bus_valid, bus_we, int_pending, busy, set_i, entry_done;
  logic [15:0] bus_addr, new_pc;
  logic [7:0]  bus_wdata, new_sp;

  int total = 0;
  int bad   = 0;
  int seti_cnt;

  always #4 clk = ~clk;

  irq_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .nmi_line(nmi_line),
    .irq_src(irq_src), .mask_wr(mask_wr), .mask_din(mask_din), .i_flag(i_flag),
    .at_boundary(at_boundary), .brk_exec(brk_exec), .cur_pc(cur_pc),
    .cur_sp(cur_sp), .cur_status(cur_status), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_pending(int_pending),
    .busy(busy), .set_i(set_i), .entry_done(entry_done), .new_pc(new_pc),
    .new_sp(new_sp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input bit brk, input logic [7:0] s);
    return brk ? (s | 8'h30) : ((s & 8'hEF) | 8'h20);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cyc_en = 1'b1; nmi_line = 1'b0; irq_src = '0; mask_wr = 1'b0;
    mask_din = '0; i_flag = 1'b1; at_boundary = 1'b0; brk_exec = 1'b0;
    bus_ready = 1'b0; bus_rdata = '0; cur_pc = '0; cur_sp = '0; cur_status = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 maskable, 1 nmi, 2 break
  task automatic run_entry(input int kind, input bit hijack, input bit late);
    logic [15:0] pc, pushpc, vec;
    logic [7:0]  sp, st, vlo, vhi;
    logic [15:0] ea[7];
    logic        ew[7];
    logic [7:0]  ed[7];
    int          n, k, stall;
    bit          brk, vn, hold_ok;
    brk = (kind == 2);
    pc = 16'($urandom); sp = 8'($urandom); st = 8'($urandom);
    vlo = 8'($urandom); vhi = 8'($urandom);
    if (kind == 0) begin
      i_flag = 1'b0; irq_src = 8'(1 << ($urandom % 8));
      repeat (2) @(negedge clk);
    end else if (kind == 1) begin
      nmi_line = 1'b1;
      repeat (2) @(negedge clk);
    end
    if (kind != 2) chk(int_pending == 1'b1, "R2/R3", "pending before entry", int_pending, 1);
    cur_pc = pc; cur_sp = sp; cur_status = st;
    at_boundary = 1'b1; brk_exec = brk;
    @(negedge clk);
    at_boundary = 1'b0; brk_exec = 1'b0; irq_src = '0; i_flag = 1'b1;
    vn = (kind == 1) || hijack;
    vec = vn ? 16'hFFFA : 16'hFFFE;
    pushpc = pc + (brk ? 16'd1 : 16'd0);
    k = 0;
    if (!brk) begin ea[k] = pc; ew[k] = 0; ed[k] = 0; k++; end
    ea[k] = pc;                     ew[k] = 0; ed[k] = 0;            k++;
    ea[k] = {8'h01, sp};            ew[k] = 1; ed[k] = pushpc[15:8]; k++;
    ea[k] = {8'h01, 8'(sp - 8'd1)}; ew[k] = 1; ed[k] = pushpc[7:0];  k++;
    ea[k] = {8'h01, 8'(sp - 8'd2)}; ew[k] = 1; ed[k] = exp_stat(brk, st); k++;
    ea[k] = vec;                    ew[k] = 0; ed[k] = 0;            k++;
    ea[k] = vec + 16'd1;            ew[k] = 0; ed[k] = 0;            k++;
    n = k;
    seti_cnt = 0;
    hold_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      stall = $urandom % 3;
      if (hijack && i == 1) begin nmi_line = 1'b1; stall = 2; end
      if (late && i == n - 1) begin nmi_line = 1'b1; stall = 3; end
      for (int j = 0; j < stall; j++) begin
        bus_ready = 1'b0;
        @(negedge clk);
        if (!bus_valid || bus_addr !== ea[i] || bus_we !== ew[i]) hold_ok = 1'b0;
      end
      chk(bus_valid && bus_addr == ea[i] && bus_we == ew[i], brk ? "R7" : "R4",
          $sformatf("op %0d addr", i), bus_addr, ea[i]);
      if (ew[i]) chk(bus_wdata == ed[i], brk ? "R7" : "R4",
                     $sformatf("op %0d data", i), bus_wdata, ed[i]);
      bus_rdata = (i == n - 2) ? vlo : (i == n - 1) ? vhi : 8'($urandom);
      bus_ready = 1'b1;
      #1;
      if (set_i) seti_cnt++;
      @(negedge clk);
      bus_ready = 1'b0;
    end
    chk(hold_ok, "R10", "request held under stall", hold_ok, 1);
    chk(entry_done == 1'b1, "R5", "entry_done pulse", entry_done, 1);
    chk(new_pc == {vhi, vlo}, hijack ? "R6" : "R5", "new_pc", new_pc, {vhi, vlo});
    chk(new_sp == 8'(sp - 8'd3), "R5", "new_sp", new_sp, 8'(sp - 8'd3));
    chk(seti_cnt == 1, "R5", "set_i count", seti_cnt, 1);
    if (late) begin
      chk(int_pending == (brk ? 1'b0 : 1'b1), "R8", "pending at done",
          int_pending, brk ? 0 : 1);
      @(negedge clk);
      chk(int_pending == 1'b1, "R8", "pending one cycle later", int_pending, 1);
      do_reset();
    end else begin
      @(negedge clk);
      chk(entry_done == 1'b0, "R5", "done is one cycle", entry_done, 0);
      repeat (3) @(negedge clk);
      chk(int_pending == 1'b0, (vn ? "R6" : "R5"), "no request after entry", int_pending, 0);
      nmi_line = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd2024);
    do_reset();
    // R1 reset state
    chk(!bus_valid && !busy && !int_pending && !entry_done, "R1", "idle after reset",
        {bus_valid, busy, int_pending, entry_done}, 0);
    i_flag = 1'b0; irq_src = 8'h80;
    repeat (2) @(negedge clk);
    chk(int_pending == 1'b1, "R1", "mask resets to all ones", int_pending, 1);
    irq_src = '0; i_flag = 1'b1;
    repeat (3) @(negedge clk);

    // R11 boundary with no cause
    at_boundary = 1'b1;
    @(negedge clk);
    at_boundary = 1'b0;
    chk(!bus_valid && !busy, "R11", "idle boundary starts nothing", bus_valid, 0);

    // R2 detection latency and cyc_en gating
    cyc_en = 1'b0; nmi_line = 1'b1;
    repeat (3) @(negedge clk);
    chk(int_pending == 1'b0, "R2", "no detect while cyc_en low", int_pending, 0);
    cyc_en = 1'b1;
    @(negedge clk);
    chk(int_pending == 1'b0, "R2", "not yet after one edge", int_pending, 0);
    @(negedge clk);
    chk(int_pending == 1'b1, "R2", "pending after two edges", int_pending, 1);
    do_reset();

    // R3 maskable timing and I flag
    i_flag = 1'b0; irq_src = 8'h02;
    @(negedge clk);
    chk(int_pending == 1'b0, "R3", "irq not after one edge", int_pending, 0);
    @(negedge clk);
    chk(int_pending == 1'b1, "R3", "irq after two edges", int_pending, 1);
    i_flag = 1'b1;
    repeat (2) @(negedge clk);
    chk(int_pending == 1'b0, "R3", "blocked by I flag", int_pending, 0);
    irq_src = '0;

    // R9 mask write
    mask_din = 8'h04; mask_wr = 1'b1;
    @(negedge clk);
    mask_wr = 1'b0; i_flag = 1'b0; irq_src = 8'hFB;
    repeat (3) @(negedge clk);
    chk(int_pending == 1'b0, "R9", "masked sources ignored", int_pending, 0);
    irq_src = 8'h04;
    repeat (2) @(negedge clk);
    chk(int_pending == 1'b1, "R9", "unmasked source seen", int_pending, 1);
    do_reset();

    // directed entries
    run_entry(0, 1'b0, 1'b0);  // R4 maskable entry
    run_entry(1, 1'b0, 1'b0);  // R5 nmi entry, level held
    run_entry(0, 1'b1, 1'b0);  // R6 nmi hijacks maskable entry
    run_entry(2, 1'b0, 1'b0);  // R7 break
    run_entry(2, 1'b1, 1'b0);  // R7 break hijacked
    run_entry(2, 1'b0, 1'b1);  // R8 late nmi after break
    run_entry(0, 1'b0, 1'b1);  // R8 contrast: hardware entry keeps request

    // random mix
    for (int t = 0; t < 30; t++) begin
      run_entry(int'($urandom % 3), bit'($urandom % 2), 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule